// File: doc/BRIEF.md
# Two-Step Conversion Sequencer with Eight-Way Input Select

This block is the digital control core of a subranging converter. The comparator bank, the reference ladder and the track-and-hold stay outside it. A host drives an active-low write strobe. While the strobe is low, the analog front end follows the selected input. When the strobe goes high, the block takes the 3-bit channel address and walks a fixed sequence: sample, coarse compare, fine compare, then a correction step.

Two 15-bit thermometer words come back from the comparators. The block reduces each word to a 4-bit count and joins the coarse count (upper nibble) and the fine count (lower nibble) into an 8-bit offset-binary code. The correction step then fixes up a fine stage that ran to the top of its range.

The 8-bit data port floats from the start of a conversion until the new code is ready. At that point the port is enabled and a one-cycle completion pulse marks the result. The block also produces the two comparator phase signals and a one-hot channel select for the input multiplexer.

Top module: `subrange_adc_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the block is idle: bus_en=0, done=0, phi_c=0 and chan_onehot=8'h01.
- R2: The first clock edge that sees wr_n high, having seen it low at the previous edge, while the block is idle, starts a conversion. It captures chan_addr, and chan_onehot shows bit chan_addr set (000 gives bit 0, 111 gives bit 7) from the next cycle. A later change of chan_addr has no effect until the next start.
- R3: With the default phase lengths (sample 1, coarse 2, fine 2, correction 1), done is high for exactly one cycle: the cycle that follows the sixth clock edge after the start edge.
- R4: bus_en falls at the start edge and stays low for the whole conversion. It rises together with done and stays high until the next start. data_bus carries the result whenever bus_en is 1.
- R5: Each thermometer word is reduced to the position of its highest set bit plus one, so 0 when no bit is set. This means a word with holes (bubbles) below its top bit decodes as if it were full.
- R6: Without correction, the code is {coarse count, fine count} in offset binary. Both words empty gives 8'h00 (negative full scale), coarse count 8 with fine count 0 gives 8'h80 (midpoint), and coarse 15 with fine 15 gives 8'hFF.
- R7: When the fine count is 15 and the coarse count is below 15, the code becomes {coarse+1, 4'h0}. Coarse 15 with fine 15 stays 8'hFF.
- R8: phi_s is high while idle with wr_n low, and during the sample phase. phi_c is high during the coarse and fine compare phases. The two are never high together.
- R9: Strobe edges that arrive during a conversion (falling or rising) are ignored. The running conversion finishes on its normal schedule, and no second conversion starts from those edges.
- R10: A reset during a conversion aborts it. bus_en and done are low after that edge, and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Write strobe: low = track, rising edge = start |
| chan_addr | input | 3 | Channel address, captured at start |
| coarse_therm | input | 15 | Coarse comparator thermometer word |
| fine_therm | input | 15 | Fine comparator thermometer word |
| chan_onehot | output | 8 | One-hot select for the input multiplexer |
| phi_s | output | 1 | Comparator sample phase |
| phi_c | output | 1 | Comparator compare phase |
| done | output | 1 | One-cycle result-ready pulse |
| bus_en | output | 1 | Data port drive enable |
| data_bus | output | 8 | Result code, high impedance while bus_en is 0 |

## Verification
The bench targets five corner cases, each tied to a specific failure:
- Correction boundaries. It checks coarse 14 with fine 15, coarse 15 with fine 15, and coarse 15 with fine 14. A design that lets the coarse increment wrap would return 8'h00 instead of 8'hFF, and one that skips the correction would leave an F in the lower nibble.
- Bubbled thermometer words. A popcount decoder would under-read these by one or more codes.
- Strobe toggles in mid-conversion. A sequencer that restarts on them would push done late or pulse it twice.
- Address changes in mid-conversion. A design that does not latch the address would move the one-hot select.
- Reset during the compare phases. A design that does not abort would still raise done afterwards.

// File: rtl/adc_seq_pkg.sv
// Package: shared state encoding for the two-step conversion sequencer.
// Assumes: a single clock domain; every phase lasts at least one cycle.
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SAMPLE = 3'd1,
        ST_COARSE = 3'd2,
        ST_FINE   = 3'd3,
        ST_CORR   = 3'd4
    } seq_state_t;

endpackage

// File: rtl/therm_decode.sv
// Thermometer-to-binary reducer: returns the highest set bit position + 1,
// so that bubbles below the top bit are absorbed.
// Assumes: WIDTH >= 1; the output width holds the value WIDTH.
module therm_decode #(
    parameter int WIDTH = 15,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] therm,
    output logic [CW-1:0]    count
);
    // Scan upward; the last set bit seen sets the count.
    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (therm[i]) count = CW'(i + 1);
        end
    end
endmodule

// File: rtl/code_correct.sv
// Subrange overlap fix-up: a fine count at full scale carries into the
// coarse field unless the coarse field is already at full scale.
// Assumes: both counts are NW bits wide and fit their fields.
module code_correct #(
    parameter int NW = 4,
    localparam int OW = 2 * NW
) (
    input  logic [NW-1:0] coarse_cnt,
    input  logic [NW-1:0] fine_cnt,
    output logic [OW-1:0] code
);
    localparam logic [NW-1:0] FULL = {NW{1'b1}};

    // Assemble, carrying a saturated fine count into the coarse field.
    always_comb begin
        if (fine_cnt == FULL && coarse_cnt != FULL)
            code = {coarse_cnt + NW'(1), {NW{1'b0}}};
        else
            code = {coarse_cnt, fine_cnt};
    end
endmodule

// File: rtl/seq_ctrl.sv
// Phase sequencer: detects the accepted strobe rise, steps sample, coarse,
// fine and correction phases of parameter length, and emits the capture
// strobes and comparator phases.
// Assumes: wr_n is synchronous to clk; all phase lengths >= 1.
module seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SAMP_CYC   = 1,
    parameter int COARSE_CYC = 2,
    parameter int FINE_CYC   = 2,
    parameter int CORR_CYC   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    output logic start,
    output logic coarse_take,
    output logic fine_take,
    output logic finish,
    output logic phi_s,
    output logic phi_c
);
    localparam int M1    = (SAMP_CYC > COARSE_CYC) ? SAMP_CYC : COARSE_CYC;
    localparam int M2    = (FINE_CYC > CORR_CYC) ? FINE_CYC : CORR_CYC;
    localparam int MAXC  = (M1 > M2) ? M1 : M2;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

    seq_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic              wr_q;
    logic              last;

    // Last cycle of the current phase.
    always_comb begin
        unique case (state)
            ST_SAMPLE: last = (cnt == CNT_W'(SAMP_CYC - 1));
            ST_COARSE: last = (cnt == CNT_W'(COARSE_CYC - 1));
            ST_FINE:   last = (cnt == CNT_W'(FINE_CYC - 1));
            ST_CORR:   last = (cnt == CNT_W'(CORR_CYC - 1));
            default:   last = 1'b0;
        endcase
    end

    assign start       = (state == ST_IDLE) && wr_n && !wr_q;
    assign coarse_take = (state == ST_COARSE) && last;
    assign fine_take   = (state == ST_FINE) && last;
    assign finish      = (state == ST_CORR) && last;
    assign phi_s       = ((state == ST_IDLE) && !wr_n) || (state == ST_SAMPLE);
    assign phi_c       = (state == ST_COARSE) || (state == ST_FINE);

    // State, phase counter and strobe history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            wr_q  <= 1'b1;
        end else begin
            wr_q <= wr_n;
            if (state == ST_IDLE) begin
                cnt <= '0;
                if (start) state <= ST_SAMPLE;
            end else if (last) begin
                cnt <= '0;
                unique case (state)
                    ST_SAMPLE: state <= ST_COARSE;
                    ST_COARSE: state <= ST_FINE;
                    ST_FINE:   state <= ST_CORR;
                    default:   state <= ST_IDLE;
                endcase
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/subrange_adc_seq.sv
// Top: two-step converter controller. Latches the channel at start, takes
// coarse and fine thermometer words at the end of their compare phases,
// corrects and publishes an offset-binary code on a tri-state port.
// Assumes: comparator words are valid by the last cycle of each phase.
module subrange_adc_seq #(
    parameter int N_CH       = 8,
    parameter int COARSE_W   = 15,
    parameter int FINE_W     = 15,
    parameter int SAMP_CYC   = 1,
    parameter int COARSE_CYC = 2,
    parameter int FINE_CYC   = 2,
    parameter int CORR_CYC   = 1,
    localparam int AW        = $clog2(N_CH),
    localparam int NW        = $clog2(COARSE_W + 1),
    localparam int DW        = 2 * NW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_n,
    input  logic [AW-1:0]       chan_addr,
    input  logic [COARSE_W-1:0] coarse_therm,
    input  logic [FINE_W-1:0]   fine_therm,
    output logic [N_CH-1:0]     chan_onehot,
    output logic                phi_s,
    output logic                phi_c,
    output logic                done,
    output logic                bus_en,
    output logic [DW-1:0]       data_bus
);
    logic          start, coarse_take, fine_take, finish;
    logic [AW-1:0] chan_sel;
    logic [NW-1:0] coarse_cnt, fine_cnt, coarse_q, fine_q;
    logic [DW-1:0] code, result_q;

    seq_ctrl #(
        .SAMP_CYC(SAMP_CYC), .COARSE_CYC(COARSE_CYC),
        .FINE_CYC(FINE_CYC), .CORR_CYC(CORR_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n),
        .start(start), .coarse_take(coarse_take), .fine_take(fine_take),
        .finish(finish), .phi_s(phi_s), .phi_c(phi_c)
    );

    therm_decode #(.WIDTH(COARSE_W)) u_cdec (.therm(coarse_therm), .count(coarse_cnt));
    therm_decode #(.WIDTH(FINE_W))   u_fdec (.therm(fine_therm),   .count(fine_cnt));

    code_correct #(.NW(NW)) u_corr (.coarse_cnt(coarse_q), .fine_cnt(fine_q), .code(code));

    // One-hot channel select decoded from the latched address.
    for (genvar g = 0; g < N_CH; g++) begin : g_sel
        assign chan_onehot[g] = (chan_sel == AW'(g));
    end

    // Capture registers, result, port enable and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_sel <= '0;
            coarse_q <= '0;
            fine_q   <= '0;
            result_q <= '0;
            bus_en   <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= finish;
            if (start) begin
                chan_sel <= chan_addr;
                bus_en   <= 1'b0;
            end
            if (coarse_take) coarse_q <= coarse_cnt;
            if (fine_take)   fine_q   <= fine_cnt;
            if (finish) begin
                result_q <= code;
                bus_en   <= 1'b1;
            end
        end
    end

    assign data_bus = bus_en ? result_q : 'z;
endmodule

// File: rtl/adc_seq_checker.sv
// Checker: temporal properties of the conversion sequencer's ports.
// Assumes: default phase lengths for the done-timing property.
module adc_seq_checker #(
    parameter int N_CH = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            phi_s,
    input logic            phi_c,
    input logic            done,
    input logic            bus_en,
    input logic [N_CH-1:0] chan_onehot
);
    assert_phase_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(phi_s && phi_c));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_fine_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(phi_c, 2) && !$past(phi_c)));

    assert_float_compare_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phi_c |-> !bus_en);

    assert_done_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bus_en);

    assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chan_onehot) == 1);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!bus_en && !done));
endmodule

bind subrange_adc_seq adc_seq_checker #(.N_CH(N_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .phi_s(phi_s), .phi_c(phi_c),
    .done(done), .bus_en(bus_en), .chan_onehot(chan_onehot)
);

// File: tb/tb_subrange_adc_seq.sv
// Bench: directed corners plus seeded random conversions against a model.
module tb_subrange_adc_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic [2:0]  chan_addr = '0;
    logic [14:0] coarse_therm = '0;
    logic [14:0] fine_therm = '0;
    logic [7:0]  chan_onehot;
    logic        phi_s, phi_c, done, bus_en;
    logic [7:0]  data_bus;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    subrange_adc_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .chan_addr(chan_addr),
        .coarse_therm(coarse_therm), .fine_therm(fine_therm),
        .chan_onehot(chan_onehot), .phi_s(phi_s), .phi_c(phi_c),
        .done(done), .bus_en(bus_en), .data_bus(data_bus)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int therm_val(input logic [14:0] w);
        int v = 0;
        for (int i = 0; i < 15; i++) if (w[i]) v = i + 1;
        return v;
    endfunction

    function automatic logic [7:0] model_code(input int c, input int f);
        if (f == 15 && c < 15) return 8'((c + 1) << 4);
        return 8'((c << 4) | f);
    endfunction

    function automatic logic [14:0] mk_therm(input int n, input bit bubble);
        logic [14:0] w = 15'((32'd1 << n) - 1);
        if (bubble && n >= 3) w[$urandom % (n - 1)] = 1'b0;
        return w;
    endfunction

    // One conversion; optional strobe and address disturbance mid-way.
    task automatic convert(input logic [2:0] a, input logic [14:0] cw,
                           input logic [14:0] fw, input bit disturb);
        logic [7:0] exp = model_code(therm_val(cw), therm_val(fw));
        @(negedge clk);
        wr_n = 1'b0; chan_addr = a; coarse_therm = cw; fine_therm = fw;
        #1 chk("R8 track phase", {phi_s, phi_c}, 2'b10);
        @(negedge clk);
        wr_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (disturb && k == 1) begin wr_n = 1'b0; chan_addr = ~a; end
            if (disturb && k == 3) wr_n = 1'b1;
            case (k)
                0: begin
                    chk("R2 channel select", chan_onehot, 8'(32'd1 << a));
                    chk("R8 sample phase", {phi_s, phi_c}, 2'b10);
                    chk("R4 bus floats", bus_en, 1'b0);
                end
                1, 2, 3, 4: chk("R8 compare phase", {phi_s, phi_c, bus_en, done}, 4'b0100);
                5: chk("R3 correction no done", {phi_c, done, bus_en}, 3'b000);
                6: begin
                    chk("R3 done timing", done, 1'b1);
                    chk("R4 bus enabled", bus_en, 1'b1);
                    chk("R6 R7 code", data_bus, exp);
                    if (disturb) chk("R9 channel held", chan_onehot, 8'(32'd1 << a));
                end
                default: chk("R3 single pulse", {done, bus_en}, 2'b01);
            endcase
        end
        if (disturb) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                chk("R9 no restart", {done, bus_en}, 2'b01);
            end
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0021));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 reset state", {bus_en, done, phi_c, chan_onehot}, {3'b000, 8'h01});

        // Directed codes and correction edges.
        convert(3'd0, 15'h0000, 15'h0000, 0);          // R6 negative full scale
        convert(3'd7, mk_therm(8, 0), 15'h0000, 0);    // R6 midpoint 0x80
        convert(3'd3, 15'h7FFF, 15'h7FFF, 0);          // R7 stays FF
        convert(3'd5, mk_therm(14, 0), 15'h7FFF, 0);   // R7 carry to F0
        convert(3'd1, 15'h7FFF, mk_therm(14, 0), 0);   // R6 FE
        convert(3'd2, mk_therm(3, 0), 15'h7FFF, 0);    // R7 carry to 40
        convert(3'd6, 15'h4000, 15'h0005, 0);          // R5 bubbles: F0 after carry? no: 15,3 -> F3
        convert(3'd4, mk_therm(9, 1), mk_therm(6, 1), 0); // R5 bubble pattern
        convert(3'd2, mk_therm(5, 0), mk_therm(10, 0), 1); // R9 disturbance

        // R10: reset during compare.
        @(negedge clk); wr_n = 1'b0; chan_addr = 3'd6;
        @(negedge clk); wr_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 abort state", {bus_en, done, phi_c, chan_onehot}, {3'b000, 8'h01});
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R10 no done after abort", {done, bus_en}, 2'b00);
        end

        // Seeded random conversions.
        for (int t = 0; t < 40; t++) begin
            convert(3'($urandom % 8), mk_therm($urandom % 16, 1'($urandom % 2)),
                    mk_therm($urandom % 16, 1'($urandom % 2)), 1'(t % 7 == 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule